// File: doc/BRIEF.md
# Serial NOR Flash Command Responder

This block behaves like a small serial NOR flash device on the slave side of an SPI link. A mode-0 shift front end hands it one received byte at a time, tagged by a single-cycle strobe, together with the active-low chip select. In return the block keeps a registered reply byte ready for the front end to shift out during the next byte slot. The first byte of every chip-select window is taken as an opcode. The block then steps through the byte phases of that command: address bytes, dummy bytes, a selector byte, data in and data out.

Storage is an internal byte array of parameterized size. A status byte carries two live flags, write-in-progress and the write-enable latch. Its protection, continuous-program and write-lock fields always read as zero. Programming a page or erasing a sector or the whole array requires the latch to be set first. Either operation holds the device busy for a parameterized time after chip select rises. Erase fills its region with 0xFF, one byte per clock, while the device is busy.

Top module: `spi_nor_responder`

## Requirements
- R1: After reset, and on any cycle where chip select was already high on the previous cycle, `tx_data` is 0xFF. The status byte reads 0x00 after reset.
- R2: The first byte of a window selects the command. Recognised opcodes are 0x06, 0x04, 0x9F, 0x05, 0x03, 0x02, 0x20, 0x60, 0xC7 and 0x90. Any other first byte makes the whole window ignored: every reply is 0xFF and no state changes until chip select rises.
- R3: Opcode 0x9F replies with three bytes: MFR_ID, then 0x20, then DEV_ID. Later bytes in the window reply 0xFF.
- R4: Opcode 0x05 replies with the status byte on every following byte for as long as chip select stays low. Bit 0 is write-in-progress and bit 1 is the write-enable latch. Bits 2 to 7 read 0.
- R5: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcodes 0x02, 0x20, 0x60 and 0xC7 are ignored while the latch is clear. The latch clears when a program or erase starts.
- R6: Opcode 0x03 takes a 24-bit address, most significant byte first. The byte slot after the last address byte returns the byte at that address. Each further slot returns the next address. The array index is the address modulo MEM_BYTES, so reading wraps at the end of memory.
- R7: Opcode 0x02 takes a 24-bit address, most significant byte first, then data bytes until chip select rises. Each data byte is ANDed into the stored byte. The low 8 address bits advance per byte and wrap inside the same 256-byte page.
- R8: Opcode 0x20 followed by three address bytes erases, to 0xFF, the SECTOR_BYTES-sized sector containing the address; the low address bits are ignored. If chip select rises before the third address byte, nothing is erased and the latch stays set.
- R9: Opcodes 0x60 and 0xC7 both erase the whole array to 0xFF.
- R10: An accepted program or erase sets write-in-progress from the cycle after chip select rises. The flag stays set for at least BUSY_CYCLES cycles and, for an erase, until every byte of the region is 0xFF. While the flag is set, every opcode except 0x05 is ignored.
- R11: Opcode 0x90 is followed by two dummy bytes and a selector byte. A zero selector returns MFR_ID and then DEV_ID; a nonzero selector returns DEV_ID and then MFR_ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select from the front end, active low, synchronous to clk |
| rx_valid | input | 1 | One-cycle strobe: a full byte has been received |
| rx_data | input | 8 | Received byte, valid with rx_valid |
| tx_data | output | 8 | Reply byte for the next byte slot |

## Verification
The bench builds the block with a 2048-byte array, 512-byte sectors and a busy time of 60 cycles. These values make both wrap cases reachable: the page wrap at column 0xFF and the end-of-memory wrap at address 0x7FF. A sector erase also outlasts the busy timer, so the check that an erase stays busy until its fill completes is meaningful. Page 0x700 sits outside sector 0, which shows that a sector erase leaves its neighbours untouched.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDID   = 8'h9F;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SECT   = 8'h20;
    localparam logic [7:0] OP_CHIP_A = 8'h60;
    localparam logic [7:0] OP_CHIP_B = 8'hC7;
    localparam logic [7:0] OP_IDSEL  = 8'h90;

    localparam logic [7:0] MEM_TYPE_CODE = 8'h20;
    localparam logic [7:0] IDLE_BYTE     = 8'hFF;
    localparam int         PAGE_BYTES    = 256;
    localparam logic [2:0] PHASE_MAX     = 3'd5;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_WEN,
        CMD_WDIS,
        CMD_IDENT,
        CMD_STAT,
        CMD_READ,
        CMD_PROG,
        CMD_SECT,
        CMD_CHIP,
        CMD_IDSEL,
        CMD_SKIP
    } cmd_e;

    typedef enum logic [1:0] {
        MEM_IDLE,
        MEM_AND,
        MEM_FILL
    } mem_op_e;

    typedef struct packed {
        logic       wr_lock;
        logic       cont_prog;
        logic [3:0] protect;
        logic       wel;
        logic       wip;
    } status_t;

    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            OP_WREN:              return CMD_WEN;
            OP_WRDI:              return CMD_WDIS;
            OP_RDID:              return CMD_IDENT;
            OP_RDSR:              return CMD_STAT;
            OP_READ:              return CMD_READ;
            OP_PROG:              return CMD_PROG;
            OP_SECT:              return CMD_SECT;
            OP_CHIP_A, OP_CHIP_B: return CMD_CHIP;
            OP_IDSEL:             return CMD_IDSEL;
            default:              return CMD_SKIP;
        endcase
    endfunction

    function automatic logic needs_wel(input cmd_e c);
        return (c == CMD_PROG) || (c == CMD_SECT) || (c == CMD_CHIP);
    endfunction

    function automatic logic [7:0] pack_status(input logic wel, input logic wip);
        status_t s;
        s     = '0;
        s.wel = wel;
        s.wip = wip;
        return s;
    endfunction

endpackage

// File: rtl/spi_nor_array.sv
module spi_nor_array
    import spi_nor_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    localparam int IDX_W    = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  mem_op_e          wr_op,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data
);

    logic [7:0] cells [MEM_BYTES];

    always_ff @(posedge clk) begin
        case (wr_op)
            MEM_AND:  cells[wr_idx] <= cells[wr_idx] & wr_data;
            MEM_FILL: cells[wr_idx] <= IDLE_BYTE;
            default:  ;
        endcase
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/spi_nor_status.sv
module spi_nor_status
    import spi_nor_pkg::*;
#(
    parameter int MEM_BYTES   = 2048,
    parameter int BUSY_CYCLES = 64,
    localparam int IDX_W      = $clog2(MEM_BYTES),
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_wel,
    input  logic             clr_wel,
    input  logic             start_prog,
    input  logic             start_erase,
    input  logic [IDX_W-1:0] erase_base,
    input  logic [IDX_W:0]   erase_len,
    output logic             wel,
    output logic             wip,
    output logic             fill_en,
    output logic [IDX_W-1:0] fill_idx
);

    logic             wel_q;
    logic [CNT_W-1:0] busy_q;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W:0]   left_q;
    logic             start;

    assign start = start_prog || start_erase;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            busy_q <= '0;
            ptr_q  <= '0;
            left_q <= '0;
        end else begin
            if (start)        wel_q <= 1'b0;
            else if (set_wel) wel_q <= 1'b1;
            else if (clr_wel) wel_q <= 1'b0;

            if (start)              busy_q <= CNT_W'(BUSY_CYCLES);
            else if (busy_q != '0)  busy_q <= busy_q - 1'b1;

            if (start_erase) begin
                ptr_q  <= erase_base;
                left_q <= erase_len;
            end else if (left_q != '0) begin
                ptr_q  <= ptr_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign wel      = wel_q;
    assign wip      = (busy_q != '0) || (left_q != '0);
    assign fill_en  = (left_q != '0);
    assign fill_idx = ptr_q;

    // R5: the sequencer only starts a program or erase with the latch set
    a_r5_start_needs_wel: assert property (@(posedge clk) disable iff (rst)
        (start_prog || start_erase) |-> wel_q);

    // R5: accepting the operation drops the latch
    a_r5_wel_dropped: assert property (@(posedge clk) disable iff (rst)
        (start_prog || start_erase) |=> !wel_q);

    // R10: busy flag follows an accepted operation
    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start_prog || start_erase) |=> wip);

    // R10: the sequencer never starts a new operation while busy
    a_r10_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start_prog || start_erase) |-> !wip);

endmodule

// File: rtl/spi_nor_seq.sv
module spi_nor_seq
    import spi_nor_pkg::*;
#(
    parameter int          MEM_BYTES    = 2048,
    parameter int          SECTOR_BYTES = 512,
    parameter logic [7:0]  MFR_ID       = 8'h3B,
    parameter logic [7:0]  DEV_ID       = 8'h16,
    localparam int         IDX_W        = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic [7:0]       tx_data,
    input  logic             wel,
    input  logic             wip,
    output logic             set_wel,
    output logic             clr_wel,
    output logic             start_prog,
    output logic             start_erase,
    output logic [IDX_W-1:0] erase_base,
    output logic [IDX_W:0]   erase_len,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data,
    output mem_op_e          wr_op,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);

    localparam logic [IDX_W-1:0] SECT_MASK = ~IDX_W'(SECTOR_BYTES - 1);
    localparam logic [IDX_W-1:0] PAGE_MASK = ~IDX_W'(PAGE_BYTES - 1);

    logic        cs_q;
    logic [2:0]  phase_q, phase_n;
    cmd_e        cmd_q, cmd_n, op;
    logic [23:0] addr_q, addr_n, addr_shift, addr_inc;
    logic [7:0]  col_q, col_n;
    logic        sel_q, sel_n;
    logic        pprog_q, pprog_n;
    logic        perase_q, perase_n;
    logic        pchip_q, pchip_n;
    logic [7:0]  tx_q, tx_n;
    logic [7:0]  stat_byte;
    logic        cs_rise;

    assign addr_shift = {addr_q[15:0], rx_data};
    assign addr_inc   = addr_q + 24'd1;
    assign stat_byte  = pack_status(wel, wip);
    assign cs_rise    = cs_n && !cs_q;

    always_comb begin
        phase_n  = phase_q;
        cmd_n    = cmd_q;
        addr_n   = addr_q;
        col_n    = col_q;
        sel_n    = sel_q;
        pprog_n  = pprog_q;
        perase_n = perase_q;
        pchip_n  = pchip_q;
        tx_n     = tx_q;
        op       = CMD_NONE;
        set_wel  = 1'b0;
        clr_wel  = 1'b0;
        rd_idx   = addr_q[IDX_W-1:0];
        wr_op    = MEM_IDLE;
        wr_idx   = (addr_q[IDX_W-1:0] & PAGE_MASK) | IDX_W'(col_q);
        wr_data  = rx_data;

        if (cs_n) begin
            phase_n  = '0;
            cmd_n    = CMD_NONE;
            pprog_n  = 1'b0;
            perase_n = 1'b0;
            pchip_n  = 1'b0;
            tx_n     = IDLE_BYTE;
        end else if (rx_valid) begin
            if (phase_q != PHASE_MAX) phase_n = phase_q + 3'd1;
            tx_n = IDLE_BYTE;
            if (phase_q == 3'd0) begin
                op = decode_op(rx_data);
                if (wip && op != CMD_STAT)   op = CMD_SKIP;
                if (needs_wel(op) && !wel)   op = CMD_SKIP;
                cmd_n = op;
                case (op)
                    CMD_WEN:   set_wel = 1'b1;
                    CMD_WDIS:  clr_wel = 1'b1;
                    CMD_STAT:  tx_n    = stat_byte;
                    CMD_IDENT: tx_n    = MFR_ID;
                    CMD_PROG:  pprog_n = 1'b1;
                    CMD_CHIP: begin
                        perase_n = 1'b1;
                        pchip_n  = 1'b1;
                    end
                    default: ;
                endcase
            end else begin
                case (cmd_q)
                    CMD_STAT: tx_n = stat_byte;
                    CMD_IDENT: begin
                        if (phase_q == 3'd1)      tx_n = MEM_TYPE_CODE;
                        else if (phase_q == 3'd2) tx_n = DEV_ID;
                    end
                    CMD_READ: begin
                        if (phase_q <= 3'd3) begin
                            addr_n = addr_shift;
                            if (phase_q == 3'd3) begin
                                rd_idx = addr_shift[IDX_W-1:0];
                                tx_n   = rd_data;
                            end
                        end else begin
                            addr_n = addr_inc;
                            rd_idx = addr_inc[IDX_W-1:0];
                            tx_n   = rd_data;
                        end
                    end
                    CMD_PROG: begin
                        if (phase_q <= 3'd3) begin
                            addr_n = addr_shift;
                            if (phase_q == 3'd3) col_n = rx_data;
                        end else begin
                            wr_op = MEM_AND;
                            col_n = col_q + 8'd1;
                        end
                    end
                    CMD_SECT: begin
                        if (phase_q <= 3'd3) begin
                            addr_n = addr_shift;
                            if (phase_q == 3'd3) perase_n = 1'b1;
                        end
                    end
                    CMD_IDSEL: begin
                        if (phase_q == 3'd3) begin
                            sel_n = (rx_data != 8'h00);
                            tx_n  = (rx_data != 8'h00) ? DEV_ID : MFR_ID;
                        end else if (phase_q == 3'd4) begin
                            tx_n = sel_q ? MFR_ID : DEV_ID;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q     <= 1'b1;
            phase_q  <= '0;
            cmd_q    <= CMD_NONE;
            addr_q   <= '0;
            col_q    <= '0;
            sel_q    <= 1'b0;
            pprog_q  <= 1'b0;
            perase_q <= 1'b0;
            pchip_q  <= 1'b0;
            tx_q     <= IDLE_BYTE;
        end else begin
            cs_q     <= cs_n;
            phase_q  <= phase_n;
            cmd_q    <= cmd_n;
            addr_q   <= addr_n;
            col_q    <= col_n;
            sel_q    <= sel_n;
            pprog_q  <= pprog_n;
            perase_q <= perase_n;
            pchip_q  <= pchip_n;
            tx_q     <= tx_n;
        end
    end

    assign tx_data     = tx_q;
    assign start_prog  = cs_rise && pprog_q;
    assign start_erase = cs_rise && perase_q;
    assign erase_base  = pchip_q ? '0 : (addr_q[IDX_W-1:0] & SECT_MASK);
    assign erase_len   = pchip_q ? (IDX_W+1)'(MEM_BYTES) : (IDX_W+1)'(SECTOR_BYTES);

    // R1: idle reply once chip select has been high for a cycle
    a_r1_idle_reply: assert property (@(posedge clk) disable iff (rst)
        (cs_n && cs_q) |-> (tx_data == IDLE_BYTE));

    // R2: an ignored window never drives anything but the idle byte
    a_r2_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_SKIP) |-> (tx_data == IDLE_BYTE));

    // R10: page writes never land while the device is busy
    a_r10_no_prog_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_op == MEM_AND) |-> !wip);

    // R5: program and erase windows only exist with the latch set
    a_r5_pending_needs_wel: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && (pprog_q || perase_q)) |-> wel);

endmodule

// File: rtl/spi_nor_responder.sv
module spi_nor_responder
    import spi_nor_pkg::*;
#(
    parameter int         MEM_BYTES    = 2048,
    parameter int         SECTOR_BYTES = 512,
    parameter int         BUSY_CYCLES  = 64,
    parameter logic [7:0] MFR_ID       = 8'h3B,
    parameter logic [7:0] DEV_ID       = 8'h16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic [7:0] tx_data
);

    localparam int IDX_W = $clog2(MEM_BYTES);

    logic             set_wel, clr_wel, start_prog, start_erase;
    logic             wel, wip, fill_en;
    logic [IDX_W-1:0] erase_base, fill_idx, rd_idx, seq_wr_idx, arr_wr_idx;
    logic [IDX_W:0]   erase_len;
    logic [7:0]       rd_data, seq_wr_data, arr_wr_data;
    mem_op_e          seq_wr_op, arr_wr_op;

    spi_nor_seq #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .MFR_ID       (MFR_ID),
        .DEV_ID       (DEV_ID)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .tx_data     (tx_data),
        .wel         (wel),
        .wip         (wip),
        .set_wel     (set_wel),
        .clr_wel     (clr_wel),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .erase_base  (erase_base),
        .erase_len   (erase_len),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .wr_op       (seq_wr_op),
        .wr_idx      (seq_wr_idx),
        .wr_data     (seq_wr_data)
    );

    spi_nor_status #(
        .MEM_BYTES   (MEM_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_status (
        .clk         (clk),
        .rst         (rst),
        .set_wel     (set_wel),
        .clr_wel     (clr_wel),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .erase_base  (erase_base),
        .erase_len   (erase_len),
        .wel         (wel),
        .wip         (wip),
        .fill_en     (fill_en),
        .fill_idx    (fill_idx)
    );

    always_comb begin
        if (fill_en) begin
            arr_wr_op   = MEM_FILL;
            arr_wr_idx  = fill_idx;
            arr_wr_data = IDLE_BYTE;
        end else begin
            arr_wr_op   = seq_wr_op;
            arr_wr_idx  = seq_wr_idx;
            arr_wr_data = seq_wr_data;
        end
    end

    spi_nor_array #(
        .MEM_BYTES (MEM_BYTES)
    ) u_array (
        .clk     (clk),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_op   (arr_wr_op),
        .wr_idx  (arr_wr_idx),
        .wr_data (arr_wr_data)
    );

    // R10: erase fill and page writes never compete for the array
    a_r10_no_write_clash: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> (seq_wr_op == MEM_IDLE));

endmodule

// File: tb/spi_nor_responder_tb.sv
module spi_nor_responder_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         MEM_BYTES  = 2048;
    localparam int         SECT_BYTES = 512;
    localparam int         BUSY       = 60;
    localparam logic [7:0] MFR        = 8'h3B;
    localparam logic [7:0] DEV        = 8'h15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [7:0] tx_data;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;

    spi_nor_responder #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECT_BYTES),
        .BUSY_CYCLES  (BUSY),
        .MFR_ID       (MFR),
        .DEV_ID       (DEV)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .tx_data  (tx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic sel_lo();
        @(negedge clk); cs_n = 1'b0;
    endtask

    task automatic sel_hi();
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        r        = tx_data;
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] r;
        sel_lo(); xfer(op, r); sel_hi();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel_lo(); xfer(8'h05, r); xfer(8'h00, s); sel_hi();
    endtask

    task automatic send_addr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        xfer(op, r); xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    endtask

    task automatic read2(input logic [23:0] a, output logic [7:0] d0, output logic [7:0] d1);
        sel_lo(); send_addr(8'h03, a); xfer(8'h00, d0); xfer(8'h00, d1); sel_hi();
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        logic       done = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) begin
            rdsr(s);
            if (!s[0]) done = 1'b1;
        end
        chk(req, "device returns to idle", int'(done), 1);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1", "tx after reset", tx_data, 8'hFF);
        rdsr(s);
        chk("R1", "status after reset", s, 8'h00);
    endtask

    task automatic t_latch_and_chip_erase();
        logic [7:0] s, d0, d1;
        one_op(8'h06); rdsr(s);
        chk("R5", "latch set by 0x06", s, 8'h02);
        one_op(8'h04); rdsr(s);
        chk("R5", "latch cleared by 0x04", s, 8'h00);
        one_op(8'h06); one_op(8'hC7); rdsr(s);
        chk("R10", "busy after chip erase 0xC7", s[0], 1);
        chk("R5", "latch dropped on erase", s[1], 0);
        wait_idle("R9");
        read2(24'h000000, d0, d1);
        chk("R9", "byte 0 erased", d0, 8'hFF);
        read2(24'h0007FE, d0, d1);
        chk("R9", "byte 0x7FF erased", d1, 8'hFF);
    endtask

    task automatic t_ident();
        logic [7:0] r0, r1, r2, r3;
        sel_lo(); xfer(8'h9F, r0); xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3); sel_hi();
        chk("R3", "id byte 1", r0, MFR);
        chk("R3", "id byte 2", r1, 8'h20);
        chk("R3", "id byte 3", r2, DEV);
        chk("R3", "id trailing", r3, 8'hFF);
    endtask

    task automatic t_idsel();
        logic [7:0] r, a, b;
        sel_lo(); xfer(8'h90, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h00, r);
        xfer(8'h00, a); xfer(8'h00, b); sel_hi();
        chk("R11", "sel 0 first", a, MFR);
        chk("R11", "sel 0 second", b, DEV);
        sel_lo(); xfer(8'h90, r); xfer(8'h00, r); xfer(8'h00, r); xfer(8'h01, r);
        xfer(8'h00, a); xfer(8'h00, b); sel_hi();
        chk("R11", "sel 1 first", a, DEV);
        chk("R11", "sel 1 second", b, MFR);
    endtask

    task automatic t_program();
        logic [7:0] r, d0, d1;
        sel_lo(); send_addr(8'h02, 24'h000010); xfer(8'h12, r); sel_hi();
        read2(24'h000010, d0, d1);
        chk("R5", "program without latch ignored", d0, 8'hFF);
        one_op(8'h06);
        sel_lo(); send_addr(8'h02, 24'h0000FE); xfer(8'h0F, r); xfer(8'hF0, r); xfer(8'h3C, r); sel_hi();
        wait_idle("R10");
        read2(24'h0000FE, d0, d1);
        chk("R7", "byte 0xFE", d0, 8'h0F);
        chk("R7", "byte 0xFF", d1, 8'hF0);
        read2(24'h000000, d0, d1);
        chk("R7", "page wrap to 0x00", d0, 8'h3C);
        one_op(8'h06);
        sel_lo(); send_addr(8'h02, 24'h0000FE); xfer(8'hF3, r); sel_hi();
        wait_idle("R10");
        read2(24'h0000FE, d0, d1);
        chk("R7", "AND into stored byte", d0, 8'h03);
    endtask

    task automatic t_busy();
        logic [7:0] r, s, a, b;
        int t0, t1;
        logic done = 1'b0;
        one_op(8'h06);
        sel_lo(); send_addr(8'h02, 24'h000100); xfer(8'hAA, r); sel_hi();
        t0 = cycle;
        rdsr(s);
        chk("R10", "busy right after program", s[0], 1);
        sel_lo(); xfer(8'h9F, r); xfer(8'h00, a); xfer(8'h00, b); sel_hi();
        chk("R10", "ident ignored while busy", a, 8'hFF);
        one_op(8'h06);
        for (int i = 0; i < 200 && !done; i++) begin
            rdsr(s);
            if (!s[0]) done = 1'b1;
        end
        t1 = cycle;
        chk("R10", "program finishes", int'(done), 1);
        chk("R10", "busy lasted at least BUSY", int'((t1 - t0) >= BUSY), 1);
        chk("R10", "0x06 ignored while busy", s[1], 0);
    endtask

    task automatic t_read_wrap();
        logic [7:0] r, d0, d1;
        one_op(8'h06);
        sel_lo(); send_addr(8'h02, 24'h0007FF); xfer(8'h5A, r); xfer(8'hA5, r); sel_hi();
        wait_idle("R10");
        read2(24'h0007FF, d0, d1);
        chk("R6", "read at last byte", d0, 8'h5A);
        chk("R6", "read wraps to byte 0", d1, 8'h3C);
        read2(24'h000700, d0, d1);
        chk("R7", "page wrap at 0x7FF", d0, 8'hA5);
        read2(24'h000100, d0, d1);
        chk("R6", "read 0x100", d0, 8'hAA);
    endtask

    task automatic t_sector();
        logic [7:0] r, s, d0, d1;
        one_op(8'h06);
        sel_lo(); xfer(8'h20, r); xfer(8'h00, r); xfer(8'h00, r); sel_hi();
        rdsr(s);
        chk("R8", "short erase not started, latch kept", s, 8'h02);
        read2(24'h0000FE, d0, d1);
        chk("R8", "short erase leaves data", d0, 8'h03);
        sel_lo(); send_addr(8'h20, 24'h000110); sel_hi();
        repeat (100) @(negedge clk);
        rdsr(s);
        chk("R10", "still busy while sector fills", s[0], 1);
        wait_idle("R10");
        read2(24'h0000FE, d0, d1);
        chk("R8", "sector byte 0xFE erased", d0, 8'hFF);
        read2(24'h000100, d0, d1);
        chk("R8", "sector byte 0x100 erased", d0, 8'hFF);
        read2(24'h0007FF, d0, d1);
        chk("R8", "other sector untouched", d0, 8'h5A);
    endtask

    task automatic t_unknown();
        logic [7:0] r, a, b, s;
        sel_lo(); xfer(8'hAB, r); xfer(8'h9F, a); xfer(8'h06, b); xfer(8'h00, r); sel_hi();
        chk("R2", "unknown opcode reply", b, 8'hFF);
        chk("R2", "no ident inside ignored window", r, 8'hFF);
        rdsr(s);
        chk("R2", "no latch change in ignored window", s, 8'h00);
    endtask

    task automatic t_stat_repeat();
        logic [7:0] r, s0, s1, s2;
        one_op(8'h06);
        sel_lo(); xfer(8'h05, r); xfer(8'h00, s0); xfer(8'h00, s1); xfer(8'h00, s2); sel_hi();
        chk("R4", "status repeat 1", s0, 8'h02);
        chk("R4", "status repeat 3", s2, 8'h02);
        one_op(8'h60);
        wait_idle("R9");
        read2(24'h0007FF, s0, s1);
        chk("R9", "chip erase 0x60", s0, 8'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latch_and_chip_erase();
        t_ident();
        t_idsel();
        t_program();
        t_busy();
        t_read_wrap();
        t_sector();
        t_unknown();
        t_stat_repeat();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule